// File: doc/BRIEF.md
# Write-Once System Options Register

This block holds an 8-bit system configuration byte on a simple CPU bus. After every reset, only the first write to it is accepted. All later writes are dropped until the next reset. Reads return the current contents at any time. The stored fields drive these controls:

- the watchdog enable;
- the watchdog period select;
- the stop-mode enable;
- three pin-function enables: reset output, debug pin and reset pin.

The block also turns two events into registered one-cycle reset requests:

- a stop request that arrives while stop mode is disabled;
- a watchdog timeout that arrives while the watchdog is enabled.

A second bus location carries a force-reset strobe. Only transactions flagged as coming from the debug interface can use it.

Two reset inputs are present. `rst_ni` is asserted by every reset source. `por_ni` is asserted only at power-on. The reset-pin enable is cleared only by the power-on reset, and it keeps its value through every other reset. The first clock edge after `rst_ni` is released is a settling edge, and the register accepts no write on it. The watchdog counter, the clock selection and the pad multiplexers lie outside this block.

Top module: `sysopt_reg`

## Requirements
- R1: Every reset sets bits 7, 6 and 1 to 1 and clears bits 5 and 2. After a power-on reset the register reads 0xC2.
- R2: After reset, the first write to location 0 (`bus_sel_i`=0) stores the write data with bits 4 and 3 forced to 0. Every later write to location 0 leaves the register unchanged until the next reset.
- R3: `bus_rdata_o` returns the register whenever location 0 is selected, locked or not. Bits 4 and 3 always read 0. Location 1 reads 0x00.
- R4: Bit 0 (reset-pin enable) is cleared by the power-on reset. It keeps its value through a reset that asserts only `rst_ni`.
- R5: A write presented while `rst_ni` is low is ignored. Every reset clears the write lock, so the next write after the reset is accepted.
- R6: A stop request while bit 5 is 0 raises `illegal_rst_o` for exactly one cycle, one clock after the request. While bit 5 is 1, `stop_go_o` follows the request in the same cycle and no illegal-operation request is raised.
- R7: A watchdog timeout while bit 7 is 1 raises `wdog_rst_o` for one cycle, one clock later. While bit 7 is 0, a timeout raises nothing.
- R8: A write to location 1 with data bit 0 set and `bus_dbg_i`=1 raises `force_rst_o` for one cycle, one clock later. The same write with `bus_dbg_i`=0 has no effect. A write to location 1 does not consume the write-once lock of location 0.
- R9: The control outputs mirror the register bits: `wdog_en_o` mirrors bit 7, `wdog_long_o` bit 6 (1 = long period), `stop_en_o` bit 5, `rsto_pin_en_o` bit 2, `dbg_pin_en_o` bit 1 and `rst_pin_en_o` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low, asserted by every reset source |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_sel_i | input | 1 | Location select: 0 = options register, 1 = force-reset location |
| bus_dbg_i | input | 1 | Transaction originates from the debug interface |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected location |
| wdog_timeout_i | input | 1 | Watchdog timeout event |
| stop_req_i | input | 1 | Request to enter stop mode |
| wdog_en_o | output | 1 | Watchdog enable |
| wdog_long_o | output | 1 | Watchdog long-period select |
| stop_en_o | output | 1 | Stop mode enable |
| stop_go_o | output | 1 | Stop request granted |
| rsto_pin_en_o | output | 1 | Reset-output pin function enable |
| dbg_pin_en_o | output | 1 | Debug pin function enable |
| rst_pin_en_o | output | 1 | Reset pin function enable |
| illegal_rst_o | output | 1 | Illegal-operation reset request pulse |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |
| force_rst_o | output | 1 | Debug force-reset request pulse |

## Verification
The register contents and the control outputs change on the clock edge that takes an accepted write. The bench therefore samples them at the following falling edge, after the write strobe has been dropped. `bus_rdata_o` and `stop_go_o` are combinational, so they are checked a short delay after the inputs are driven, within the same low phase. The three reset-request pulses are due one edge after their trigger. Each pulse is checked high at the next falling edge and low at the falling edge after that, so both its delay and its one-cycle width are covered.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int REG_W         = 8;
  localparam int BIT_WDOG_EN   = 7;
  localparam int BIT_WDOG_LONG = 6;
  localparam int BIT_STOP_EN   = 5;
  localparam int BIT_RSTO_EN   = 2;
  localparam int BIT_DBG_PIN   = 1;
  localparam int BIT_RST_PIN   = 0;
  localparam int BIT_FORCE     = 0;
  localparam logic [REG_W-1:0] IMPL_MASK = 8'hE7;
  localparam logic [REG_W-1:0] RST_VAL   = 8'hC2;
  localparam logic [REG_W-1:0] COLD_MASK = REG_W'(1) << BIT_RST_PIN;

  typedef enum logic {
    SEL_OPTS  = 1'b0,
    SEL_FORCE = 1'b1
  } sel_e;

  typedef struct packed {
    logic illegal;
    logic wdog;
    logic force_rst;
  } req_t;
endpackage

// File: rtl/sysopt_store.sv
module sysopt_store
  import sysopt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] WARM_MASK = IMPL_MASK & ~COLD_MASK;

  logic             run_q;
  logic             locked_q;
  logic [REG_W-1:0] warm_q;
  logic             cold_q;
  logic             wr_ok;

  // run_q is low during reset and on the settling edge
  assign wr_ok = wr_i & run_q & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      locked_q <= 1'b0;
      warm_q   <= RST_VAL & WARM_MASK;
    end else begin
      run_q <= 1'b1;
      if (wr_ok) begin
        warm_q   <= wdata_i & WARM_MASK;
        locked_q <= 1'b1;
      end
    end
  end

  // survives warm resets, cleared at power-on only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cold_q <= 1'b0;
    end else if (wr_ok) begin
      cold_q <= wdata_i[BIT_RST_PIN];
    end
  end

  assign q_o = warm_q | (cold_q ? COLD_MASK : '0);
endmodule

// File: rtl/sysopt_pulse.sv
module sysopt_pulse #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[g] <= 1'b0;
      else         pulse_o[g] <= ev_i[g];
    end
  end
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             bus_we_i,
  input  logic             bus_sel_i,
  input  logic             bus_dbg_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             wdog_timeout_i,
  input  logic             stop_req_i,
  output logic             wdog_en_o,
  output logic             wdog_long_o,
  output logic             stop_en_o,
  output logic             stop_go_o,
  output logic             rsto_pin_en_o,
  output logic             dbg_pin_en_o,
  output logic             rst_pin_en_o,
  output logic             illegal_rst_o,
  output logic             wdog_rst_o,
  output logic             force_rst_o
);
  localparam int NREQ = $bits(req_t);

  logic [REG_W-1:0] opts;
  logic             opt_wr;
  req_t             req_ev;
  req_t             req_q;

  assign opt_wr = bus_we_i & (sel_e'(bus_sel_i) == SEL_OPTS);

  sysopt_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_ni  (por_ni),
    .wr_i    (opt_wr),
    .wdata_i (bus_wdata_i),
    .q_o     (opts)
  );

  assign wdog_en_o     = opts[BIT_WDOG_EN];
  assign wdog_long_o   = opts[BIT_WDOG_LONG];
  assign stop_en_o     = opts[BIT_STOP_EN];
  assign rsto_pin_en_o = opts[BIT_RSTO_EN];
  assign dbg_pin_en_o  = opts[BIT_DBG_PIN];
  assign rst_pin_en_o  = opts[BIT_RST_PIN];

  assign stop_go_o = stop_req_i & opts[BIT_STOP_EN];

  always_comb begin
    req_ev.illegal   = stop_req_i & ~opts[BIT_STOP_EN];
    req_ev.wdog      = wdog_timeout_i & opts[BIT_WDOG_EN];
    // debug-origin writes only
    req_ev.force_rst = bus_we_i & (sel_e'(bus_sel_i) == SEL_FORCE)
                     & bus_dbg_i & bus_wdata_i[BIT_FORCE];
  end

  sysopt_pulse #(.N(NREQ)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (req_ev),
    .pulse_o (req_q)
  );

  assign illegal_rst_o = req_q.illegal;
  assign wdog_rst_o    = req_q.wdog;
  assign force_rst_o   = req_q.force_rst;

  assign bus_rdata_o = (sel_e'(bus_sel_i) == SEL_OPTS) ? opts : '0;
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk
  import sysopt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             bus_we_i,
  input logic             bus_sel_i,
  input logic             bus_dbg_i,
  input logic [REG_W-1:0] bus_wdata_i,
  input logic [REG_W-1:0] bus_rdata_o,
  input logic             wdog_timeout_i,
  input logic             stop_req_i,
  input logic             wdog_en_o,
  input logic             wdog_long_o,
  input logic             stop_en_o,
  input logic             stop_go_o,
  input logic             rsto_pin_en_o,
  input logic             dbg_pin_en_o,
  input logic             rst_pin_en_o,
  input logic             illegal_rst_o,
  input logic             wdog_rst_o,
  input logic             force_rst_o
);
  logic             armed_q;
  logic             seen_q;
  logic [REG_W-1:0] ctrl;
  logic             opt_wr;

  assign ctrl   = {wdog_en_o, wdog_long_o, stop_en_o, 2'b00,
                   rsto_pin_en_o, dbg_pin_en_o, rst_pin_en_o};
  assign opt_wr = bus_we_i && !bus_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (opt_wr && armed_q) seen_q <= 1'b1;
    end
  end

  p_first_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_wr && armed_q && !seen_q) |=> (ctrl == ($past(bus_wdata_i) & IMPL_MASK)));

  p_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_wr && seen_q) |=> $stable(ctrl));

  p_unimpl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[4:3] == 2'b00);

  p_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && !stop_en_o) |=> illegal_rst_o);

  p_no_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_req_i || stop_en_o) |=> !illegal_rst_o);

  p_wdog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_timeout_i && wdog_en_o) |=> wdog_rst_o);

  p_wdog_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdog_en_o |=> !wdog_rst_o);

  p_force_cpu_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_sel_i && !bus_dbg_i) |=> !force_rst_o);

  p_force_dbg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_sel_i && bus_dbg_i && bus_wdata_i[BIT_FORCE]) |=> force_rst_o);
endmodule

bind sysopt_reg sysopt_reg_chk u_chk (.*);

// File: tb/sysopt_reg_tb.sv
module sysopt_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic       bus_dbg_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       wdog_timeout_i = 1'b0;
  logic       stop_req_i = 1'b0;
  logic       wdog_en_o, wdog_long_o, stop_en_o, stop_go_o;
  logic       rsto_pin_en_o, dbg_pin_en_o, rst_pin_en_o;
  logic       illegal_rst_o, wdog_rst_o, force_rst_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysopt_reg u_dut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] ctrl_now();
    return {wdog_en_o, wdog_long_o, stop_en_o, 2'b00,
            rsto_pin_en_o, dbg_pin_en_o, rst_pin_en_o};
  endfunction

  task automatic do_reset(input bit por);
    @(negedge clk_i);
    rst_ni = 1'b0;
    if (por) por_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    por_ni = 1'b1;
    @(negedge clk_i); // settling edge passes before next write
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d, input logic dbg);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_sel_i = sel; bus_wdata_i = d; bus_dbg_i = dbg;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_dbg_i = 1'b0; bus_sel_i = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic sel, input logic [7:0] exp);
    bus_sel_i = sel;
    #1;
    chk(req, bus_rdata_o, exp);
    bus_sel_i = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // sweep every write value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] val;
      val = 8'(v);
      do_reset(1'b1);
      read_chk("R1 por value", 1'b0, 8'hC2);
      chk("R9 ctrl after reset", ctrl_now(), 8'hC2);
      bus_write(1'b0, val, 1'b0);
      read_chk("R2 first write", 1'b0, val & 8'hE7);
      chk("R9 ctrl mirror", ctrl_now(), val & 8'hE7);
      bus_write(1'b0, ~val, 1'b0);
      read_chk("R2 second write ignored", 1'b0, val & 8'hE7);
      read_chk("R3 location1 reads zero", 1'b1, 8'h00);
      do_reset(1'b0);
      read_chk("R4 warm reset keeps bit0", 1'b0, 8'hC2 | (val & 8'h01));
    end

    // R5 write during reset ignored, lock cleared
    do_reset(1'b1);
    bus_write(1'b0, 8'h01, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    bus_we_i = 1'b1; bus_sel_i = 1'b0; bus_wdata_i = 8'h20;
    repeat (2) @(negedge clk_i);
    bus_we_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_chk("R5 write in reset ignored", 1'b0, 8'hC3);
    bus_write(1'b0, 8'h20, 1'b0);
    read_chk("R5 lock cleared by reset", 1'b0, 8'h20);

    // R6/R7 with stop and watchdog disabled
    do_reset(1'b1);
    bus_write(1'b0, 8'h00, 1'b0);
    @(negedge clk_i);
    stop_req_i = 1'b1;
    #1 chk("R6 no stop_go when disabled", {7'd0, stop_go_o}, 8'h00);
    chk("R6 illegal not early", {7'd0, illegal_rst_o}, 8'h00);
    @(negedge clk_i);
    stop_req_i = 1'b0;
    chk("R6 illegal pulse", {7'd0, illegal_rst_o}, 8'h01);
    @(negedge clk_i);
    chk("R6 illegal one cycle", {7'd0, illegal_rst_o}, 8'h00);
    wdog_timeout_i = 1'b1;
    @(negedge clk_i);
    wdog_timeout_i = 1'b0;
    chk("R7 no wdog reset when off", {7'd0, wdog_rst_o}, 8'h00);

    // R6/R7 with stop and watchdog enabled
    do_reset(1'b1);
    bus_write(1'b0, 8'hA0, 1'b0);
    @(negedge clk_i);
    stop_req_i = 1'b1;
    #1 chk("R6 stop_go same cycle", {7'd0, stop_go_o}, 8'h01);
    @(negedge clk_i);
    stop_req_i = 1'b0;
    chk("R6 no illegal when enabled", {7'd0, illegal_rst_o}, 8'h00);
    #1 chk("R6 stop_go drops", {7'd0, stop_go_o}, 8'h00);
    wdog_timeout_i = 1'b1;
    @(negedge clk_i);
    wdog_timeout_i = 1'b0;
    chk("R7 wdog reset pulse", {7'd0, wdog_rst_o}, 8'h01);
    @(negedge clk_i);
    chk("R7 wdog reset one cycle", {7'd0, wdog_rst_o}, 8'h00);

    // R8 force reset
    do_reset(1'b1);
    bus_write(1'b1, 8'h01, 1'b0);
    chk("R8 cpu force ignored", {7'd0, force_rst_o}, 8'h00);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_sel_i = 1'b1; bus_wdata_i = 8'h01; bus_dbg_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_sel_i = 1'b0; bus_dbg_i = 1'b0;
    chk("R8 debug force pulse", {7'd0, force_rst_o}, 8'h01);
    @(negedge clk_i);
    chk("R8 force one cycle", {7'd0, force_rst_o}, 8'h00);
    read_chk("R8 options untouched", 1'b0, 8'hC2);
    bus_write(1'b0, 8'h45, 1'b0);
    read_chk("R8 lock not consumed", 1'b0, 8'h45);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule